// File: doc/BRIEF.md
# Linear Page-Table Refill Engine

This controller sits next to a translation lookaside buffer and services its misses. When a lookup for some virtual address misses, the requester hands that address to the engine. The engine computes where the matching page-table entry lives inside a flat, virtually addressed table. The table has one 4-byte entry per 4 KB page, so it covers the full 32-bit space in 4 MB. The engine translates that entry address through the same TLB at ring 0. It then issues exactly one memory read and installs the returned word as a new TLB entry. Finally it tells the requester to retry the original access.

There is no multi-level walk. If the entry address cannot be translated, the engine stops and reports a TLB-miss exception. If the requester was already in exception mode, it reports a double exception instead. Software is expected to handle these exceptions. A fetched entry whose attribute field carries the invalid encoding is reported at once as a bad entry and is not installed.

Installed entries go into a set chosen by two bits of the page number. The way within that set is picked by a per-set round-robin pointer. Only one miss is in service at a time.

Top module: `pt_refill_engine`

## Requirements
- R1: The entry address presented on the lookup port equals `ptbase` plus the faulting virtual address shifted right by 10 with its two low bits cleared (that is, `ptbase + {vaddr[31:12], 2'b00}`), with 32-bit wraparound.
- R2: A refill issues exactly one memory read, at the physical address returned by the lookup. `rd_valid` holds, with `rd_addr` stable, until `rd_ready` accepts it. A request that ends in an exception issues no read.
- R3: Both the lookup and the read are marked ring 0: `lk_ring` and `rd_ring` are 2'b00 whenever their valid is high.
- R4: If the entry lookup misses and `miss_excm` was 0 at acceptance, the engine responds with code 1 (TLB-miss exception) in the cycle after the lookup. It makes no read and no TLB write.
- R5: If the entry lookup misses and `miss_excm` was 1 at acceptance, the response code is 2 (double exception).
- R6: On a good read, the engine writes one TLB entry with `tlb_wr_vpn = vaddr[31:12]` and `tlb_wr_pte` = the read data, in the cycle after the read data. In the following cycle it responds with code 0 (retry).
- R7: If the read data has bits [3:0] equal to 4'hF (invalid attribute), the response is code 3 (bad entry) in the cycle after the data, and no TLB write is made.
- R8: The written set is `vaddr[13:12]`. The way comes from a per-set pointer that starts at 0 after reset and steps 0,1,2,3,0 with each write to that set only.
- R9: `miss_ready` is high only when the engine is idle. It is high after reset with all other valid outputs low. It returns high in the cycle after each response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ptbase | input | 32 | Virtual base of the linear page table |
| miss_valid | input | 1 | Miss request valid |
| miss_ready | output | 1 | Engine idle, request accepted when both high |
| miss_vaddr | input | 32 | Faulting virtual address |
| miss_excm | input | 1 | Requester already in exception mode |
| lk_valid | output | 1 | Entry-address lookup request |
| lk_vaddr | output | 32 | Virtual address of the page-table entry |
| lk_ring | output | 2 | Privilege ring of the lookup |
| lk_hit | input | 1 | Lookup found a valid translation (same cycle) |
| lk_paddr | input | 32 | Translated physical address |
| rd_valid | output | 1 | Memory read request |
| rd_ready | input | 1 | Memory accepts the read |
| rd_addr | output | 32 | Physical read address |
| rd_ring | output | 2 | Privilege ring of the read |
| rd_rvalid | input | 1 | Read data valid |
| rd_rdata | input | 32 | Read data (page-table entry) |
| tlb_wr_valid | output | 1 | TLB write strobe |
| tlb_wr_set | output | 2 | Target set |
| tlb_wr_way | output | 2 | Target way |
| tlb_wr_vpn | output | 20 | Virtual page number of the entry |
| tlb_wr_pte | output | 32 | Entry contents |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_code | output | 2 | 0 retry, 1 TLB-miss exception, 2 double exception, 3 bad entry |

## Verification
The bench builds the block with its defaults: 32-bit addresses, 4 KB pages, 4-byte entries, four sets of four ways and a 4-bit attribute field. With four ways, a handful of directed refills to one set carries that set's pointer through its wrap. Refills to other sets show that their pointers do not move. The narrow attribute field lets the random stream draw both invalid and valid entries often. Random read-accept and data latencies exercise request holding and single-read behaviour. A base near the top of the address space exercises the adder's wraparound.

// File: rtl/rfl_pkg.sv
package rfl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_XLATE_PTE = 3'd1,
    ST_READ      = 3'd2,
    ST_WRITE_TLB = 3'd3,
    ST_DONE      = 3'd4,
    ST_FAULT     = 3'd5
  } rfl_state_e;

  typedef enum logic [1:0] {
    RSP_RETRY      = 2'd0,
    RSP_MISS_EXC   = 2'd1,
    RSP_DOUBLE_EXC = 2'd2,
    RSP_BAD_PTE    = 2'd3
  } rfl_rsp_e;

endpackage

// File: rtl/rfl_rst_sync.sv
module rfl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/rfl_addr_gen.sv
module rfl_addr_gen #(
  parameter int VA_W       = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int ENTRY_LOG2 = 2,
  parameter int SET_BITS   = 2,
  localparam int VPN_W     = VA_W - PAGE_SHIFT
) (
  input  logic [VA_W-1:0]     fault_vaddr,
  input  logic [VA_W-1:0]     table_base,
  output logic [VA_W-1:0]     entry_vaddr,
  output logic [VPN_W-1:0]    page_num,
  output logic [SET_BITS-1:0] set_idx
);
  localparam int PAD_W = PAGE_SHIFT - ENTRY_LOG2;

  logic [VA_W-1:0] entry_offset;

  assign page_num     = fault_vaddr[VA_W-1:PAGE_SHIFT];
  assign entry_offset = {{PAD_W{1'b0}}, page_num, {ENTRY_LOG2{1'b0}}};
  assign entry_vaddr  = table_base + entry_offset;
  assign set_idx      = fault_vaddr[PAGE_SHIFT+SET_BITS-1:PAGE_SHIFT];
endmodule

// File: rtl/rfl_victim_rr.sv
module rfl_victim_rr #(
  parameter int SETS      = 4,
  parameter int WAYS      = 4,
  localparam int SET_BITS = $clog2(SETS),
  localparam int WAY_BITS = $clog2(WAYS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SET_BITS-1:0] sel_set,
  input  logic                advance,
  output logic [WAY_BITS-1:0] victim_way
);
  localparam logic [WAY_BITS-1:0] LAST_WAY = WAY_BITS'(WAYS - 1);

  logic [WAY_BITS-1:0] ptr_q [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic                step_en;
    logic [WAY_BITS-1:0] ptr_d;

    assign step_en = advance && (sel_set == SET_BITS'(s));

    always_comb begin
      if (ptr_q[s] == LAST_WAY) ptr_d = '0;
      else                      ptr_d = ptr_q[s] + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ptr_q[s] <= '0;
      else if (step_en) ptr_q[s] <= ptr_d;
    end
  end

  assign victim_way = ptr_q[sel_set];
endmodule

// File: rtl/rfl_fsm.sv
module rfl_fsm
  import rfl_pkg::*;
#(
  parameter int VA_W                 = 32,
  parameter int PA_W                 = 32,
  parameter int PTE_W                = 32,
  parameter int ATTR_W               = 4,
  parameter logic [ATTR_W-1:0] ATTR_INVALID = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             miss_valid,
  output logic             miss_ready,
  input  logic [VA_W-1:0]  miss_vaddr,
  input  logic             miss_excm,
  output logic [VA_W-1:0]  held_vaddr,
  output logic             lk_valid,
  input  logic             lk_hit,
  input  logic [PA_W-1:0]  lk_paddr,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [PA_W-1:0]  rd_addr,
  input  logic             rd_rvalid,
  input  logic [PTE_W-1:0] rd_rdata,
  output logic             tlb_wr_valid,
  output logic [PTE_W-1:0] tlb_wr_pte,
  output logic             rsp_valid,
  output logic [1:0]       rsp_code
);
  rfl_state_e       state_q, state_d;
  logic [VA_W-1:0]  vaddr_q;
  logic             excm_q;
  logic [PA_W-1:0]  paddr_q;
  logic [PTE_W-1:0] pte_q;
  logic             issued_q, issued_d;
  rfl_rsp_e         code_q, code_d;

  logic accept, paddr_en, pte_en, code_en, issue_fire, pte_bad;

  assign accept     = (state_q == ST_IDLE) && miss_valid;
  assign issue_fire = rd_valid && rd_ready;
  assign pte_bad    = (rd_rdata[ATTR_W-1:0] == ATTR_INVALID);

  always_comb begin
    state_d  = state_q;
    code_d   = code_q;
    code_en  = 1'b0;
    paddr_en = 1'b0;
    pte_en   = 1'b0;
    issued_d = issued_q;
    if (accept)     issued_d = 1'b0;
    if (issue_fire) issued_d = 1'b1;
    case (state_q)
      ST_IDLE: begin
        if (miss_valid) state_d = ST_XLATE_PTE;
      end
      ST_XLATE_PTE: begin
        if (lk_hit) begin
          state_d  = ST_READ;
          paddr_en = 1'b1;
        end else begin
          state_d = ST_FAULT;
          code_en = 1'b1;
          code_d  = excm_q ? RSP_DOUBLE_EXC : RSP_MISS_EXC;
        end
      end
      ST_READ: begin
        if (issued_q && rd_rvalid) begin
          if (pte_bad) begin
            state_d = ST_FAULT;
            code_en = 1'b1;
            code_d  = RSP_BAD_PTE;
          end else begin
            state_d = ST_WRITE_TLB;
            pte_en  = 1'b1;
          end
        end
      end
      ST_WRITE_TLB: state_d = ST_DONE;
      ST_DONE:      state_d = ST_IDLE;
      ST_FAULT:     state_d = ST_IDLE;
      default:      state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      issued_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      issued_q <= issued_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vaddr_q <= '0;
      excm_q  <= 1'b0;
    end else if (accept) begin
      vaddr_q <= miss_vaddr;
      excm_q  <= miss_excm;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        paddr_q <= '0;
    else if (paddr_en) paddr_q <= lk_paddr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pte_q <= '0;
    else if (pte_en) pte_q <= rd_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= RSP_RETRY;
    else if (code_en) code_q <= code_d;
  end

  assign miss_ready   = (state_q == ST_IDLE);
  assign held_vaddr   = vaddr_q;
  assign lk_valid     = (state_q == ST_XLATE_PTE);
  assign rd_valid     = (state_q == ST_READ) && !issued_q;
  assign rd_addr      = paddr_q;
  assign tlb_wr_valid = (state_q == ST_WRITE_TLB);
  assign tlb_wr_pte   = pte_q;
  assign rsp_valid    = (state_q == ST_DONE) || (state_q == ST_FAULT);
  assign rsp_code     = (state_q == ST_DONE) ? RSP_RETRY : code_q;
endmodule

// File: rtl/pt_refill_engine.sv
module pt_refill_engine #(
  parameter int VA_W       = 32,
  parameter int PA_W       = 32,
  parameter int PTE_W      = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int ENTRY_LOG2 = 2,
  parameter int SETS       = 4,
  parameter int WAYS       = 4,
  parameter int ATTR_W     = 4,
  parameter logic [ATTR_W-1:0] ATTR_INVALID = '1,
  localparam int VPN_W     = VA_W - PAGE_SHIFT,
  localparam int SET_BITS  = $clog2(SETS),
  localparam int WAY_BITS  = $clog2(WAYS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [VA_W-1:0]     ptbase,
  input  logic                miss_valid,
  output logic                miss_ready,
  input  logic [VA_W-1:0]     miss_vaddr,
  input  logic                miss_excm,
  output logic                lk_valid,
  output logic [VA_W-1:0]     lk_vaddr,
  output logic [1:0]          lk_ring,
  input  logic                lk_hit,
  input  logic [PA_W-1:0]     lk_paddr,
  output logic                rd_valid,
  input  logic                rd_ready,
  output logic [PA_W-1:0]     rd_addr,
  output logic [1:0]          rd_ring,
  input  logic                rd_rvalid,
  input  logic [PTE_W-1:0]    rd_rdata,
  output logic                tlb_wr_valid,
  output logic [SET_BITS-1:0] tlb_wr_set,
  output logic [WAY_BITS-1:0] tlb_wr_way,
  output logic [VPN_W-1:0]    tlb_wr_vpn,
  output logic [PTE_W-1:0]    tlb_wr_pte,
  output logic                rsp_valid,
  output logic [1:0]          rsp_code
);
  localparam logic [1:0] KERNEL_RING = 2'b00;

  logic                rst_int_n;
  logic [VA_W-1:0]     held_vaddr;
  logic [SET_BITS-1:0] set_idx;

  rfl_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  rfl_addr_gen #(
    .VA_W       (VA_W),
    .PAGE_SHIFT (PAGE_SHIFT),
    .ENTRY_LOG2 (ENTRY_LOG2),
    .SET_BITS   (SET_BITS)
  ) u_addr (
    .fault_vaddr (held_vaddr),
    .table_base  (ptbase),
    .entry_vaddr (lk_vaddr),
    .page_num    (tlb_wr_vpn),
    .set_idx     (set_idx)
  );

  rfl_fsm #(
    .VA_W         (VA_W),
    .PA_W         (PA_W),
    .PTE_W        (PTE_W),
    .ATTR_W       (ATTR_W),
    .ATTR_INVALID (ATTR_INVALID)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .miss_valid   (miss_valid),
    .miss_ready   (miss_ready),
    .miss_vaddr   (miss_vaddr),
    .miss_excm    (miss_excm),
    .held_vaddr   (held_vaddr),
    .lk_valid     (lk_valid),
    .lk_hit       (lk_hit),
    .lk_paddr     (lk_paddr),
    .rd_valid     (rd_valid),
    .rd_ready     (rd_ready),
    .rd_addr      (rd_addr),
    .rd_rvalid    (rd_rvalid),
    .rd_rdata     (rd_rdata),
    .tlb_wr_valid (tlb_wr_valid),
    .tlb_wr_pte   (tlb_wr_pte),
    .rsp_valid    (rsp_valid),
    .rsp_code     (rsp_code)
  );

  rfl_victim_rr #(
    .SETS (SETS),
    .WAYS (WAYS)
  ) u_victim (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .sel_set    (set_idx),
    .advance    (tlb_wr_valid),
    .victim_way (tlb_wr_way)
  );

  assign tlb_wr_set = set_idx;
  assign lk_ring    = KERNEL_RING;
  assign rd_ring    = KERNEL_RING;
endmodule

// File: rtl/pt_refill_engine_chk.sv
module pt_refill_engine_chk #(
  parameter int VA_W       = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int ENTRY_LOG2 = 2,
  parameter int SET_BITS   = 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic [VA_W-1:0]     ptbase,
  input logic                miss_valid,
  input logic                miss_ready,
  input logic [VA_W-1:0]     miss_vaddr,
  input logic                miss_excm,
  input logic                lk_valid,
  input logic [VA_W-1:0]     lk_vaddr,
  input logic                rd_valid,
  input logic                rd_ready,
  input logic [VA_W-1:0]     rd_addr,
  input logic                tlb_wr_valid,
  input logic [SET_BITS-1:0] tlb_wr_set,
  input logic                rsp_valid,
  input logic [1:0]          rsp_code
);
  localparam int PAD_W = PAGE_SHIFT - ENTRY_LOG2;

  logic [VA_W-1:0] cap_vaddr;
  logic            cap_excm;
  logic [1:0]      rd_cnt;
  logic [VA_W-1:0] exp_entry;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_vaddr <= '0;
      cap_excm  <= 1'b0;
      rd_cnt    <= '0;
    end else if (miss_valid && miss_ready) begin
      cap_vaddr <= miss_vaddr;
      cap_excm  <= miss_excm;
      rd_cnt    <= '0;
    end else if (rd_valid && rd_ready && rd_cnt != 2'b11) begin
      rd_cnt <= rd_cnt + 1'b1;
    end
  end

  assign exp_entry = ptbase + {{PAD_W{1'b0}}, cap_vaddr[VA_W-1:PAGE_SHIFT], {ENTRY_LOG2{1'b0}}};

  // R1
  entry_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> lk_vaddr == exp_entry);

  // R2
  single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready) |-> rd_cnt == 2'd0);

  // R2
  read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

  // R4
  miss_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == 2'd1) |-> (!cap_excm && rd_cnt == 2'd0));

  // R5
  double_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == 2'd2) |-> (cap_excm && rd_cnt == 2'd0));

  // R6
  write_then_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_wr_valid |=> (rsp_valid && rsp_code == 2'd0));

  // R6
  retry_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == 2'd0) |-> rd_cnt == 2'd1);

  // R8
  write_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_wr_valid |-> tlb_wr_set == cap_vaddr[PAGE_SHIFT+SET_BITS-1:PAGE_SHIFT]);

  // R9
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid || rd_valid || tlb_wr_valid || rsp_valid) |-> !miss_ready);

  // R9
  back_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> miss_ready);
endmodule

bind pt_refill_engine pt_refill_engine_chk #(
  .VA_W       (VA_W),
  .PAGE_SHIFT (PAGE_SHIFT),
  .ENTRY_LOG2 (ENTRY_LOG2),
  .SET_BITS   (SET_BITS)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .ptbase       (ptbase),
  .miss_valid   (miss_valid),
  .miss_ready   (miss_ready),
  .miss_vaddr   (miss_vaddr),
  .miss_excm    (miss_excm),
  .lk_valid     (lk_valid),
  .lk_vaddr     (lk_vaddr),
  .rd_valid     (rd_valid),
  .rd_ready     (rd_ready),
  .rd_addr      (rd_addr),
  .tlb_wr_valid (tlb_wr_valid),
  .tlb_wr_set   (tlb_wr_set),
  .rsp_valid    (rsp_valid),
  .rsp_code     (rsp_code)
);

// File: tb/pt_refill_engine_tb_top.sv
module pt_refill_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ptbase = '0;
  logic        miss_valid = 1'b0;
  logic        miss_ready;
  logic [31:0] miss_vaddr = '0;
  logic        miss_excm = 1'b0;
  logic        lk_valid;
  logic [31:0] lk_vaddr;
  logic [1:0]  lk_ring;
  logic        lk_hit = 1'b0;
  logic [31:0] lk_paddr = '0;
  logic        rd_valid;
  logic        rd_ready = 1'b0;
  logic [31:0] rd_addr;
  logic [1:0]  rd_ring;
  logic        rd_rvalid = 1'b0;
  logic [31:0] rd_rdata = '0;
  logic        tlb_wr_valid;
  logic [1:0]  tlb_wr_set;
  logic [1:0]  tlb_wr_way;
  logic [19:0] tlb_wr_vpn;
  logic [31:0] tlb_wr_pte;
  logic        rsp_valid;
  logic [1:0]  rsp_code;

  int n_checks = 0;
  int n_fails  = 0;
  int rd_hs    = 0;
  int wr_cnt   = 0;
  int rr [4];
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pt_refill_engine dut_i (
    .clk(clk), .rst_n(rst_n), .ptbase(ptbase),
    .miss_valid(miss_valid), .miss_ready(miss_ready), .miss_vaddr(miss_vaddr), .miss_excm(miss_excm),
    .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_ring(lk_ring), .lk_hit(lk_hit), .lk_paddr(lk_paddr),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_ring(rd_ring),
    .rd_rvalid(rd_rvalid), .rd_rdata(rd_rdata),
    .tlb_wr_valid(tlb_wr_valid), .tlb_wr_set(tlb_wr_set), .tlb_wr_way(tlb_wr_way),
    .tlb_wr_vpn(tlb_wr_vpn), .tlb_wr_pte(tlb_wr_pte),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code)
  );

  always @(posedge clk) begin
    if (rd_valid && rd_ready) rd_hs <= rd_hs + 1;
    if (tlb_wr_valid)         wr_cnt <= wr_cnt + 1;
  end

  function automatic logic [31:0] f_entry(input logic [31:0] base, input logic [31:0] va);
    return base + {10'd0, va[31:12], 2'b00};
  endfunction

  function automatic logic [31:0] f_phys(input logic [31:0] ev);
    return {ev[31:12] ^ 20'hA5A5A, ev[11:0]};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_one(input logic [31:0] va, input bit excm, input bit hit,
                         input bit bad, input int acc_wait, input int lat);
    logic [31:0] ev, pa, data;
    int hs0, wr0, s;
    logic [1:0] exp_code;
    ev = f_entry(ptbase, va);
    pa = f_phys(ev);
    data = $urandom();
    if (bad) data[3:0] = 4'hF;
    else     data[3:0] = 4'($urandom_range(0, 14));
    s = int'(va[13:12]);
    hs0 = rd_hs;
    wr0 = wr_cnt;
    check(miss_ready == 1'b1, "R9 idle ready", {31'd0, miss_ready}, 32'd1);
    miss_valid = 1'b1; miss_vaddr = va; miss_excm = excm;
    @(negedge clk);
    miss_valid = 1'b0; miss_excm = 1'b0;
    check(miss_ready == 1'b0, "R9 busy", {31'd0, miss_ready}, 32'd0);
    check(lk_valid == 1'b1, "R1 lookup valid", {31'd0, lk_valid}, 32'd1);
    check(lk_vaddr == ev, "R1 entry addr", lk_vaddr, ev);
    check(lk_ring == 2'b00, "R3 lookup ring", {30'd0, lk_ring}, 32'd0);
    lk_hit = hit; lk_paddr = pa;
    @(negedge clk);
    lk_hit = 1'b0;
    if (!hit) begin
      exp_code = excm ? 2'd2 : 2'd1;
      check(rsp_valid == 1'b1, excm ? "R5 resp" : "R4 resp", {31'd0, rsp_valid}, 32'd1);
      check(rsp_code == exp_code, excm ? "R5 code" : "R4 code", {30'd0, rsp_code}, {30'd0, exp_code});
      check(rd_valid == 1'b0, "R4 no read", {31'd0, rd_valid}, 32'd0);
      @(negedge clk);
      check(miss_ready == 1'b1, "R9 ready after resp", {31'd0, miss_ready}, 32'd1);
      check(rd_hs == hs0 && wr_cnt == wr0, "R4 no read/write",
            32'(rd_hs - hs0 + wr_cnt - wr0), 32'd0);
      return;
    end
    check(rd_valid == 1'b1 && rd_addr == pa, "R2 read addr", rd_addr, pa);
    check(rd_ring == 2'b00, "R3 read ring", {30'd0, rd_ring}, 32'd0);
    for (int i = 0; i < acc_wait; i++) begin
      @(negedge clk);
      check(rd_valid == 1'b1 && rd_addr == pa, "R2 read held", rd_addr, pa);
    end
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
    check(rd_valid == 1'b0, "R2 read dropped after accept", {31'd0, rd_valid}, 32'd0);
    for (int i = 0; i < lat; i++) @(negedge clk);
    rd_rvalid = 1'b1; rd_rdata = data;
    @(negedge clk);
    rd_rvalid = 1'b0;
    if (bad) begin
      check(rsp_valid == 1'b1 && rsp_code == 2'd3, "R7 bad entry code", {30'd0, rsp_code}, 32'd3);
      check(tlb_wr_valid == 1'b0, "R7 no write", {31'd0, tlb_wr_valid}, 32'd0);
    end else begin
      check(tlb_wr_valid == 1'b1, "R6 write strobe", {31'd0, tlb_wr_valid}, 32'd1);
      check(tlb_wr_vpn == va[31:12], "R6 vpn", {12'd0, tlb_wr_vpn}, {12'd0, va[31:12]});
      check(tlb_wr_pte == data, "R6 pte", tlb_wr_pte, data);
      check(tlb_wr_set == va[13:12], "R8 set", {30'd0, tlb_wr_set}, {30'd0, va[13:12]});
      check(int'(tlb_wr_way) == rr[s], "R8 way", {30'd0, tlb_wr_way}, 32'(rr[s]));
      rr[s] = (rr[s] + 1) % 4;
      @(negedge clk);
      check(rsp_valid == 1'b1 && rsp_code == 2'd0, "R6 retry", {30'd0, rsp_code}, 32'd0);
    end
    @(negedge clk);
    check(miss_ready == 1'b1, "R9 ready after resp", {31'd0, miss_ready}, 32'd1);
    check(rd_hs == hs0 + 1, "R2 one read", 32'(rd_hs - hs0), 32'd1);
    check(wr_cnt == wr0 + (bad ? 0 : 1), bad ? "R7 write count" : "R6 write count",
          32'(wr_cnt - wr0), bad ? 32'd0 : 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed_sink;
    seed_sink = $urandom(32'd20240611);
    for (int i = 0; i < 4; i++) rr[i] = 0;
    ptbase = 32'h8000_0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(miss_ready == 1'b1, "R9 reset ready", {31'd0, miss_ready}, 32'd1);
    check(!lk_valid && !rd_valid && !tlb_wr_valid && !rsp_valid, "R9 reset valids low",
          {28'd0, lk_valid, rd_valid, tlb_wr_valid, rsp_valid}, 32'd0);
    // R8: five refills into set 1 wrap its pointer; one into set 2 starts at way 0
    for (int k = 0; k < 5; k++) run_one(32'h0040_1000 + 32'(k) * 32'h0001_0000, 1'b0, 1'b1, 1'b0, k % 2, k % 3);
    run_one(32'h1234_2ABC, 1'b0, 1'b1, 1'b0, 0, 0);
    // R4 / R5: entry lookup misses
    run_one(32'hDEAD_B000, 1'b0, 1'b0, 1'b0, 0, 0);
    run_one(32'hDEAD_B000, 1'b1, 1'b0, 1'b0, 0, 0);
    // R7: invalid attribute, then R8 pointer of the set unchanged
    run_one(32'h0000_3000, 1'b0, 1'b1, 1'b1, 2, 1);
    run_one(32'h0000_3004, 1'b0, 1'b1, 1'b0, 0, 0);
    // R1: base near top of space, entry address wraps
    ptbase = 32'hFFF0_0000;
    run_one(32'hFFFF_F000, 1'b0, 1'b1, 1'b0, 0, 0);
    run_one(32'h0000_0000, 1'b1, 1'b1, 1'b0, 1, 0);
    for (int n = 0; n < 200; n++) begin
      if (n % 50 == 0) ptbase = $urandom();
      run_one($urandom(), 1'($urandom_range(0, 1)), ($urandom_range(0, 3) != 0),
              ($urandom_range(0, 4) == 0), int'($urandom_range(0, 3)), int'($urandom_range(0, 4)));
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule